// File: doc/BRIEF.md
# Trap Priority Selector with Error-State Control

This block sits beside the trap logic of one processor core. Every cycle it looks at a vector of pending trap requests, picks the one that wins by priority number, and reports that trap's 9-bit type code with a one-cycle strobe. It keeps the nesting depth of traps in a level counter. A taken trap raises the level by one and a trap-return pulse lowers it by one. A trap that arrives when the level is already at its ceiling does not nest further. Instead it sends the core into error state.

The block also contains a progress watchdog. It counts enabled ticks and is cleared by every retire pulse. When no instruction retires for 2^WDOG_BITS ticks (2^33 by default), the core is pushed into error state. A software reset request made at the ceiling level also leads to error state. Once in error state, the block can issue a watchdog-reset pulse if a configuration input allows it. That pulse returns the core to normal running and keeps the recorded reason for the error. Only power-on reset clears that reason.

Top module: `trap_arb_errctl`

## Requirements
- R1: Request bit i maps to one type code and one priority number. Bit 0 is async data error, code 0x040, priority 2. Bit 1 is interrupt vector, 0x060, priority 16. Bit 2 is physical-address watchpoint, 0x061, priority 12. Bit 3 is virtual-address watchpoint, 0x062, priority 1. Bit 4 is ECC error, 0x063, priority 33. Bit 5 is instruction MMU miss, 0x064, priority 2. Bit 6 is data MMU miss, 0x068, priority 12. Bit 7 is data protection, 0x06C, priority 12. A taken MMU trap reports the base code of its four-code range.
- R2: Among the pending requests, the lowest priority number is taken. On equal priority numbers, the lower type code is taken.
- R3: If the level is below MAX_TL and the block is not in error state, a non-zero request vector is taken at the next clock edge. After that edge trap_taken is 1 for one cycle, trap_type holds the winner's code, and trap_level has risen by one.
- R4: A trap_ret pulse lowers trap_level by one, never below 0. trap_ret is ignored in a cycle where a trap is taken or error state is entered. trap_level never exceeds MAX_TL.
- R5: A non-zero request vector while trap_level equals MAX_TL sets err_state with err_cause 2. No trap is taken and the level is left unchanged.
- R6: sw_rst_req while trap_level equals MAX_TL sets err_state with err_cause 3. Below MAX_TL, sw_rst_req has no effect.
- R7: The watchdog counts clock edges with tick_en high, and a retire_pulse clears it. The clear wins over a tick in the same cycle. The edge that completes 2^WDOG_BITS counted ticks since the last clear sets err_state with err_cause 1.
- R8: While err_state is 1, trap requests, trap_ret, tick_en, retire_pulse and sw_rst_req are ignored. No trap is taken and trap_level holds.
- R9: If wdr_en is high, wd_reset is 1 for the one cycle after the cycle in which err_state became 1. At the next edge, err_state, trap_level and the watchdog count return to 0, and err_cause keeps its value. With wdr_en low, error state persists and wd_reset stays 0.
- R10: Power-on reset (por_n low, asynchronous) clears every output, including err_cause.
- R11: When several error conditions coincide, the cause priority is watchdog expiry (1), then software reset at the ceiling (3), then trap at the ceiling (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| trap_req | input | 8 | Pending trap lines, bit mapping per R1 |
| sw_rst_req | input | 1 | Software-initiated reset request |
| retire_pulse | input | 1 | Instruction retire progress, clears watchdog |
| trap_ret | input | 1 | Return from trap, lowers trap level |
| tick_en | input | 1 | Watchdog tick enable |
| wdr_en | input | 1 | Allows a watchdog reset after error entry |
| trap_type | output | 9 | Type code of the last trap taken |
| trap_taken | output | 1 | One-cycle strobe for a taken trap |
| trap_level | output | TL_W (3) | Current trap nesting level |
| err_state | output | 1 | Core is in error state |
| err_cause | output | 2 | Recorded reason for error entry (1, 2, 3; 0 none) |
| wd_reset | output | 1 | One-cycle watchdog-reset strobe |

## Verification
The hardest situation to reach from the ports is a watchdog expiry that lands in the same cycle as a software reset and a trap request at the ceiling level. The real timeout is 2^33 ticks, so the bench shrinks WDOG_BITS to 4. It then raises the level to MAX_TL through five traps with tick_en held low, counts exactly fifteen ticks, and drives all three conditions on the sixteenth tick. A behavioural model in the bench follows every cycle, so the retire-versus-tick clear and the two-cycle watchdog-reset sequence are also compared on every edge.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;

   localparam int NSRC   = 8;
   localparam int CODE_W = 9;
   localparam int PRIO_W = 6;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_WDOG   = 2'd1,
      CAUSE_TRAPMX = 2'd2,
      CAUSE_SWRMX  = 2'd3
   } err_cause_e;

   // type code of request line i (MMU lines report their range base)
   function automatic logic [CODE_W-1:0] src_code(input int i);
      case (i)
         0:       return 9'h040;
         1:       return 9'h060;
         2:       return 9'h061;
         3:       return 9'h062;
         4:       return 9'h063;
         5:       return 9'h064;
         6:       return 9'h068;
         default: return 9'h06C;
      endcase
   endfunction

   // priority number of request line i, lower wins
   function automatic logic [PRIO_W-1:0] src_prio(input int i);
      case (i)
         0:       return 6'd2;
         1:       return 6'd16;
         2:       return 6'd12;
         3:       return 6'd1;
         4:       return 6'd33;
         5:       return 6'd2;
         6:       return 6'd12;
         default: return 6'd12;
      endcase
   endfunction

endpackage

// File: rtl/trap_pick.sv
module trap_pick
   import trap_arb_pkg::*;
#(
   parameter int N     = NSRC,
   localparam int KEY_W = PRIO_W + CODE_W
) (
   input  logic [N-1:0]      req,
   output logic              any,
   output logic [CODE_W-1:0] code
);

   if (N != NSRC) begin : g_bad_n
      $error("trap_pick: N must equal the package source count");
   end

   logic [KEY_W-1:0] key [N];
   logic [KEY_W-1:0] best;

   // sort key: priority number above, code below, so ties go to the lower code
   for (genvar g = 0; g < N; g++) begin : g_key
      assign key[g] = {src_prio(g), src_code(g)};
   end

   always_comb begin
      best = '1;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (key[i] < best)) best = key[i];
      end
   end

   assign any  = |req;
   assign code = best[CODE_W-1:0];

endmodule

// File: rtl/trap_lvl_ctr.sv
module trap_lvl_ctr #(
   parameter int MAX_TL = 5,
   parameter int TL_W   = $clog2(MAX_TL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   input  logic            dec,
   input  logic            clr,
   output logic [TL_W-1:0] lvl,
   output logic            at_max
);

   localparam logic [TL_W-1:0] TOP = TL_W'(MAX_TL);

   assign at_max = (lvl == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  lvl <= '0;
      else if (clr)                lvl <= '0;
      else if (inc && !at_max)     lvl <= lvl + 1'b1;
      else if (dec && lvl != '0)   lvl <= lvl - 1'b1;
   end

endmodule

// File: rtl/trap_wdog.sv
module trap_wdog #(
   parameter int WDOG_BITS = 33,
   localparam int CNT_W    = WDOG_BITS + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             hold,
   output logic             expire,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << WDOG_BITS;

   assign expire = tick && !hold && !clr && (count == LIMIT - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         count <= '0;
      else if (clr)       count <= '0;
      else if (hold)      count <= count;
      else if (tick)      count <= count + 1'b1;
   end

endmodule

// File: rtl/trap_arb_errctl.sv
module trap_arb_errctl
   import trap_arb_pkg::*;
#(
   parameter int  MAX_TL    = 5,
   parameter int  WDOG_BITS = 33,
   localparam int TL_W      = $clog2(MAX_TL + 1)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [NSRC-1:0]   trap_req,
   input  logic              sw_rst_req,
   input  logic              retire_pulse,
   input  logic              trap_ret,
   input  logic              tick_en,
   input  logic              wdr_en,
   output logic [CODE_W-1:0] trap_type,
   output logic              trap_taken,
   output logic [TL_W-1:0]   trap_level,
   output logic              err_state,
   output logic [1:0]        err_cause,
   output logic              wd_reset
);

   localparam int CNT_W = WDOG_BITS + 1;

   if (MAX_TL < 1) begin : g_bad_tl
      $error("trap_arb_errctl: MAX_TL must be at least 1");
   end
   if (WDOG_BITS < 2 || WDOG_BITS > 62) begin : g_bad_wd
      $error("trap_arb_errctl: WDOG_BITS out of range");
   end

   logic              any_req, at_max, expire, norm;
   logic              sw_err, trap_err, enter_err, take, dec;
   logic [CODE_W-1:0] win_code;
   logic [CNT_W-1:0]  wd_count;
   err_cause_e        cause_q;

   trap_pick #(.N(NSRC)) u_pick (
      .req  (trap_req),
      .any  (any_req),
      .code (win_code)
   );

   trap_wdog #(.WDOG_BITS(WDOG_BITS)) u_wdog (
      .clk    (clk),
      .rst_n  (por_n),
      .clr    (wd_reset | (retire_pulse & ~err_state)),
      .tick   (tick_en),
      .hold   (err_state),
      .expire (expire),
      .count  (wd_count)
   );

   trap_lvl_ctr #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_lvl (
      .clk    (clk),
      .rst_n  (por_n),
      .inc    (take),
      .dec    (dec),
      .clr    (wd_reset),
      .lvl    (trap_level),
      .at_max (at_max)
   );

   assign norm      = !err_state && !wd_reset;
   assign sw_err    = norm && sw_rst_req && at_max;
   assign trap_err  = norm && any_req && at_max;
   assign enter_err = expire || sw_err || trap_err;
   assign take      = norm && any_req && !at_max && !expire;
   assign dec       = norm && trap_ret && !take && !enter_err;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         trap_type  <= '0;
         trap_taken <= 1'b0;
         err_state  <= 1'b0;
         wd_reset   <= 1'b0;
         cause_q    <= CAUSE_NONE;
      end else begin
         trap_taken <= take;
         if (take) trap_type <= win_code;
         if (wd_reset) begin
            err_state <= 1'b0;
            wd_reset  <= 1'b0;
         end else if (err_state) begin
            wd_reset  <= wdr_en;
         end else if (enter_err) begin
            err_state <= 1'b1;
            if (expire)      cause_q <= CAUSE_WDOG;
            else if (sw_err) cause_q <= CAUSE_SWRMX;
            else             cause_q <= CAUSE_TRAPMX;
         end
      end
   end

   assign err_cause = cause_q;

endmodule

// File: rtl/trap_arb_chk.sv
module trap_arb_chk #(
   parameter int MAX_TL = 5,
   parameter int TL_W   = 3
) (
   input logic            clk,
   input logic            por_n,
   input logic [8:0]      trap_type,
   input logic            trap_taken,
   input logic [TL_W-1:0] trap_level,
   input logic            err_state,
   input logic [1:0]      err_cause,
   input logic            wd_reset,
   input logic            wdr_en
);

   p_level_bound_r4: assert property (@(posedge clk) disable iff (!por_n)
      trap_level <= TL_W'(MAX_TL));

   p_taken_step_r3: assert property (@(posedge clk) disable iff (!por_n)
      trap_taken |-> (32'(trap_level) == 32'($past(trap_level)) + 1));

   p_code_legal_r1: assert property (@(posedge clk) disable iff (!por_n)
      trap_taken |-> (trap_type inside {9'h040, 9'h060, 9'h061, 9'h062,
                                        9'h063, 9'h064, 9'h068, 9'h06C}));

   p_no_take_in_err_r8: assert property (@(posedge clk) disable iff (!por_n)
      trap_taken |-> !err_state);

   p_err_level_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      (err_state && $past(err_state) && !wd_reset) |=> (err_state || wd_reset ||
       !$past(wd_reset)) && $stable(trap_level));

   p_cause_set_r11: assert property (@(posedge clk) disable iff (!por_n)
      err_state |-> (err_cause != 2'd0));

   p_wdr_in_err_r9: assert property (@(posedge clk) disable iff (!por_n)
      wd_reset |-> err_state);

   p_wdr_clears_r9: assert property (@(posedge clk) disable iff (!por_n)
      wd_reset |=> (!err_state && trap_level == '0 && !wd_reset &&
                    $stable(err_cause)));

   p_wdr_needs_en_r9: assert property (@(posedge clk) disable iff (!por_n)
      $rose(wd_reset) |-> $past(wdr_en));

endmodule

bind trap_arb_errctl trap_arb_chk #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_trap_arb_chk (.*);

// File: tb/test_trap_arb_errctl.sv
module test_trap_arb_errctl;

   localparam int MAXTL = 5;
   localparam int WB    = 4;
   localparam longint LIM = 64'd1 << WB;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [7:0] trap_req = '0;
   logic       sw_rst_req = 1'b0, retire_pulse = 1'b0, trap_ret = 1'b0;
   logic       tick_en = 1'b0, wdr_en = 1'b0;
   logic [8:0] trap_type;
   logic       trap_taken, err_state, wd_reset;
   logic [2:0] trap_level;
   logic [1:0] err_cause;

   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   trap_arb_errctl #(.MAX_TL(MAXTL), .WDOG_BITS(WB)) i_trap_arb_errctl (.*);

   // reference tables
   int code_t [8] = '{'h040, 'h060, 'h061, 'h062, 'h063, 'h064, 'h068, 'h06C};
   int prio_t [8] = '{2, 16, 12, 1, 33, 2, 12, 12};

   function automatic int winner(input logic [7:0] r);
      int bp = 999, bc = 999;
      for (int i = 0; i < 8; i++)
         if (r[i] && (prio_t[i] < bp || (prio_t[i] == bp && code_t[i] < bc))) begin
            bp = prio_t[i]; bc = code_t[i];
         end
      return bc;
   endfunction

   // behavioural model
   int m_tl, m_err, m_cause, m_taken, m_type, m_wdr;
   longint m_cnt;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_tl = 0; m_err = 0; m_cause = 0; m_taken = 0; m_type = 0; m_wdr = 0; m_cnt = 0;
      end else if (m_wdr != 0) begin
         m_wdr = 0; m_err = 0; m_tl = 0; m_cnt = 0; m_taken = 0;
      end else if (m_err != 0) begin
         m_taken = 0; m_wdr = wdr_en ? 1 : 0;
      end else begin
         bit exp_now, atmax;
         exp_now = tick_en && !retire_pulse && (m_cnt == LIM - 1);
         atmax   = (m_tl == MAXTL);
         if (retire_pulse) m_cnt = 0; else if (tick_en) m_cnt++;
         m_taken = 0;
         if (exp_now)                        begin m_err = 1; m_cause = 1; end
         else if (sw_rst_req && atmax)       begin m_err = 1; m_cause = 3; end
         else if (trap_req != 0 && atmax)    begin m_err = 1; m_cause = 2; end
         else if (trap_req != 0)             begin m_taken = 1; m_type = winner(trap_req); m_tl++; end
         else if (trap_ret && m_tl > 0)      m_tl--;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (por_n && !done) begin
         chk("R3 model trap_taken", trap_taken, m_taken);
         chk("R1 model trap_type", trap_type, m_type);
         chk("R4 model trap_level", trap_level, m_tl);
         chk("R8 model err_state", err_state, m_err);
         chk("R11 model err_cause", err_cause, m_cause);
         chk("R9 model wd_reset", wd_reset, m_wdr);
      end
   end

   task automatic cyc(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic take_one(input logic [7:0] r);
      trap_req = r; cyc(); trap_req = '0;
   endtask

   task automatic drop_one();
      trap_ret = 1'b1; cyc(); trap_ret = 1'b0;
   endtask

   task automatic do_por();
      por_n = 1'b0; cyc(2); por_n = 1'b1; cyc();
   endtask

   task automatic climb();
      repeat (MAXTL) take_one(8'h02);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] pv [6] = '{8'hFF, 8'h21, 8'hC4, 8'hC0, 8'h12, 8'h14};
      int         pe [6] = '{'h062, 'h040, 'h061, 'h068, 'h060, 'h061};
      cyc(3);
      chk("R10 reset taken", trap_taken, 0);
      chk("R10 reset level", trap_level, 0);
      chk("R10 reset err", err_state, 0);
      chk("R10 reset type", trap_type, 0);
      por_n = 1'b1; cyc();

      for (int i = 0; i < 8; i++) begin
         take_one(8'(1 << i));
         chk("R1 single code", trap_type, code_t[i]);
         chk("R3 taken strobe", trap_taken, 1);
         chk("R3 level up", trap_level, 1);
         drop_one();
         chk("R4 level down", trap_level, 0);
         chk("R3 strobe one cycle", trap_taken, 0);
      end

      for (int k = 0; k < 6; k++) begin
         take_one(pv[k]);
         chk("R2 priority pick", trap_type, pe[k]);
         drop_one();
      end

      drop_one();
      chk("R4 no underflow", trap_level, 0);
      trap_req = 8'h02; trap_ret = 1'b1; cyc(); trap_req = '0; trap_ret = 1'b0;
      chk("R4 ret ignored on take", trap_level, 1);
      drop_one();

      sw_rst_req = 1'b1; cyc(); sw_rst_req = 1'b0;
      chk("R6 sw reset below max", err_state, 0);
      chk("R6 level unchanged", trap_level, 0);

      wdr_en = 1'b1;
      climb();
      chk("R4 level at max", trap_level, MAXTL);
      take_one(8'h08);
      chk("R5 err entered", err_state, 1);
      chk("R5 no take", trap_taken, 0);
      chk("R5 cause", err_cause, 2);
      chk("R5 level held", trap_level, MAXTL);
      cyc();
      chk("R9 wd_reset pulse", wd_reset, 1);
      cyc();
      chk("R9 err cleared", err_state, 0);
      chk("R9 level cleared", trap_level, 0);
      chk("R9 cause kept", err_cause, 2);
      chk("R9 pulse ends", wd_reset, 0);

      wdr_en = 1'b0;
      climb();
      sw_rst_req = 1'b1; cyc(); sw_rst_req = 1'b0;
      chk("R6 sw at max err", err_state, 1);
      chk("R6 cause", err_cause, 3);
      trap_req = 8'hFF; trap_ret = 1'b1; tick_en = 1'b1; retire_pulse = 1'b1;
      cyc(4);
      chk("R8 no take in err", trap_taken, 0);
      chk("R8 level held", trap_level, MAXTL);
      chk("R9 no reset when off", wd_reset, 0);
      chk("R8 still err", err_state, 1);
      trap_req = '0; trap_ret = 1'b0; tick_en = 1'b0; retire_pulse = 1'b0;
      do_por();
      chk("R10 cause cleared", err_cause, 0);
      chk("R10 err cleared", err_state, 0);

      tick_en = 1'b1;
      cyc(int'(LIM) - 1);
      chk("R7 before limit", err_state, 0);
      retire_pulse = 1'b1; cyc(); retire_pulse = 1'b0;
      cyc(int'(LIM) - 1);
      chk("R7 clear wins over tick", err_state, 0);
      cyc();
      chk("R7 timeout err", err_state, 1);
      chk("R7 timeout cause", err_cause, 1);
      tick_en = 1'b0;
      do_por();

      climb();
      tick_en = 1'b1;
      cyc(int'(LIM) - 1);
      chk("R11 not yet", err_state, 0);
      trap_req = 8'h01; sw_rst_req = 1'b1; cyc();
      trap_req = '0; sw_rst_req = 1'b0; tick_en = 1'b0;
      chk("R11 wdog cause first", err_cause, 1);
      do_por();

      climb();
      trap_req = 8'h01; sw_rst_req = 1'b1; cyc();
      trap_req = '0; sw_rst_req = 1'b0;
      chk("R11 sw over trap", err_cause, 3);
      cyc(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule